// File: doc/BRIEF.md
# GPIO Interrupt Condition Detector

This block watches the pins of a general-purpose I/O port and turns selected pin conditions into interrupts. Every line has its own two-bit mode that selects a low-level, high-level, rising-edge or falling-edge condition. A separate per-line override bit replaces that mode with detection of any level change. Only lines that the direction mask marks as inputs can raise a condition. Pins arrive asynchronously and first pass through a synchronizer chain. The synchronized level is then compared with the level that was sampled one cycle earlier.

A detected condition sets a sticky status bit. The status bit is cleared only by a write-one-to-clear request from the register interface. One combined interrupt output is high while any status bit is set whose mask bit is also set.

Level conditions are evaluated on every cycle. A change to the direction, mode or override inputs, or a clear of the status bits, therefore takes effect at once. If a level condition is still true, it sets its status bit again on the next edge. A build parameter can remove the override feature, and the override inputs are then ignored. The block has no sequencing of its own. The house state-machine layout is kept only in its naming, its reset and its one-register-process-per-module structure.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset (rst_n low) is held and on the first cycle after it, status_o and irq_o are zero. Reset also clears the synchronizer and the previous-level register.
- R2: A line whose dir_in_i bit is 0 (output) never sets its status bit, whatever its pin, mode or override bits are.
- R3: Mode 00 on bits [2n+1:2n] of irq_cfg_i means low level: the status bit is set on each cycle that the synchronized level of the line is 0.
- R4: Mode 01 means high level: the status bit is set on each cycle that the synchronized level is 1.
- R5: Mode 10 means rising edge: the status bit is set only when the synchronized level goes from 0 to 1. A falling change does not set it.
- R6: Mode 11 means falling edge: the status bit is set only when the synchronized level goes from 1 to 0. A rising change does not set it.
- R7: When any_edge_i bit n is 1 (and HAS_ANY_EDGE is 1), the mode bits of line n are ignored and any change of level sets the status bit. A steady level does not set it.
- R8: Status bits are sticky. A status bit goes from 1 to 0 only in a cycle where clr_valid_i is 1 and clr_bits_i bit n is 1. A 0 in clr_bits_i leaves the bit unchanged.
- R9: If a clear and a detection hit the same bit in the same cycle, the detection wins and the bit stays 1.
- R10: irq_o is 1 exactly when status_o AND mask_i is nonzero. It follows a change of mask_i in the same cycle.
- R11: A pin change appears in status_o on the third rising clock edge after it is applied, and no earlier. This is two synchronizer stages plus the status register.
- R12: With HAS_ANY_EDGE = 0, any_edge_i has no effect and every line follows its two-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async_i | input | LINES | Raw pin levels, asynchronous to clk |
| dir_in_i | input | LINES | 1 = line is an input and may raise interrupts |
| irq_cfg_i | input | 2*LINES | Two mode bits per line: 00 low, 01 high, 10 rise, 11 fall |
| any_edge_i | input | LINES | Per-line override to any-edge detection |
| mask_i | input | LINES | Per-line interrupt enable for irq_o |
| clr_valid_i | input | 1 | Write-one-to-clear request strobe |
| clr_bits_i | input | LINES | Status bits to clear when clr_valid_i is 1 |
| status_o | output | LINES | Sticky interrupt status |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that the configuration inputs (dir_in_i, irq_cfg_i, any_edge_i and mask_i) are synchronous to clk and stable around each rising edge. Only pin_async_i may change freely. The bench drives every input, pins included, one time unit after the falling edge, so every value is settled before the next rising edge. In the directed phases the pins are held for at least three cycles, which lets each edge pass the synchronizer before the next edge arrives. The random phase changes pins, configuration and clears on arbitrary cycles, and a behavioural model checks both build variants against it on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    typedef enum logic [1:0] {
        MODE_LOW  = 2'b00,
        MODE_HIGH = 2'b01,
        MODE_RISE = 2'b10,
        MODE_FALL = 2'b11
    } line_mode_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic       prev_i,
    input  logic       is_input_i,
    input  logic [1:0] mode_i,
    input  logic       any_edge_i,
    output logic       hit_o
);
    line_mode_e mode;
    logic       changed;

    assign mode    = line_mode_e'(mode_i);
    assign changed = level_i ^ prev_i;

    always_comb begin
        hit_o = 1'b0;
        if (is_input_i) begin
            if (any_edge_i) begin
                hit_o = changed;
            end else begin
                unique case (mode)
                    MODE_LOW:  hit_o = !level_i;
                    MODE_HIGH: hit_o = level_i;
                    MODE_RISE: hit_o = changed && level_i;
                    MODE_FALL: hit_o = changed && !level_i;
                    default:   hit_o = 1'b0;
                endcase
            end
        end
    end

    assert_output_line_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_input_i |-> !hit_o);

    assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && mode_i[1] && !any_edge_i) |-> (level_i != prev_i));

    assert_any_edge_needs_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && any_edge_i) |-> (level_i != prev_i));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] hit_i,
    input  logic             clr_valid_i,
    input  logic [LINES-1:0] clr_bits_i,
    input  logic [LINES-1:0] mask_i,
    output logic [LINES-1:0] status_o,
    output logic             irq_o
);
    logic [LINES-1:0] status_q;
    logic [LINES-1:0] clear_eff;

    assign clear_eff = clr_valid_i ? clr_bits_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clear_eff) | hit_i;
    end

    assign status_o = status_q;
    assign irq_o    = |(status_q & mask_i);

    for (genvar n = 0; n < LINES; n++) begin : g_chk
        assert_clear_only_on_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status_q[n]) |-> $past(clr_valid_i && clr_bits_i[n]));
        assert_detect_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i[n] |=> status_q[n]);
    end

    assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_i != '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int LINES        = 32,
    parameter int SYNC_STAGES  = 2,
    parameter bit HAS_ANY_EDGE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   pin_async_i,
    input  logic [LINES-1:0]   dir_in_i,
    input  logic [2*LINES-1:0] irq_cfg_i,
    input  logic [LINES-1:0]   any_edge_i,
    input  logic [LINES-1:0]   mask_i,
    input  logic               clr_valid_i,
    input  logic [LINES-1:0]   clr_bits_i,
    output logic [LINES-1:0]   status_o,
    output logic               irq_o
);
    logic [LINES-1:0] level;
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] override;
    logic [LINES-1:0] hit;

    gpio_pin_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_async_i),
        .sync_o  (level)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    if (HAS_ANY_EDGE) begin : g_ovr
        assign override = any_edge_i;
    end else begin : g_no_ovr
        assign override = '0;
    end

    for (genvar n = 0; n < LINES; n++) begin : g_line
        gpio_line_detect u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_i    (level[n]),
            .prev_i     (prev_q[n]),
            .is_input_i (dir_in_i[n]),
            .mode_i     (irq_cfg_i[2*n+1 -: 2]),
            .any_edge_i (override[n]),
            .hit_o      (hit[n])
        );
    end

    gpio_irq_status #(.LINES(LINES)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .clr_valid_i (clr_valid_i),
        .clr_bits_i  (clr_bits_i),
        .mask_i      (mask_i),
        .status_o    (status_o),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   pins = '0;
    logic [N-1:0]   dir = '0;
    logic [2*N-1:0] cfg = '0;
    logic [N-1:0]   anye = '0;
    logic [N-1:0]   mask = '0;
    logic           clr_v = 1'b0;
    logic [N-1:0]   clr_b = '0;
    logic [N-1:0]   st, st_ne;
    logic           irq, irq_ne;

    int tests = 0;
    int fails = 0;
    string phase = "R1";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_detect uut (
        .clk(clk), .rst_n(rst_n), .pin_async_i(pins), .dir_in_i(dir),
        .irq_cfg_i(cfg), .any_edge_i(anye), .mask_i(mask),
        .clr_valid_i(clr_v), .clr_bits_i(clr_b), .status_o(st), .irq_o(irq));

    gpio_irq_detect #(.HAS_ANY_EDGE(1'b0)) uut_ne (
        .clk(clk), .rst_n(rst_n), .pin_async_i(pins), .dir_in_i(dir),
        .irq_cfg_i(cfg), .any_edge_i(anye), .mask_i(mask),
        .clr_valid_i(clr_v), .clr_bits_i(clr_b), .status_o(st_ne), .irq_o(irq_ne));

    // behavioural reference: pipeline of sampled pin words
    logic [N-1:0] m_s1, m_s2, m_prev, m_st, m_st_ne;

    function automatic logic [N-1:0] detect(logic [N-1:0] lv, logic [N-1:0] pv,
                                            logic [N-1:0] ae);
        logic [N-1:0] r = '0;
        for (int n = 0; n < N; n++) begin
            int code = {cfg[2*n+1], cfg[2*n]};
            bit moved = (lv[n] != pv[n]);
            if (!dir[n]) r[n] = 0;
            else if (ae[n]) r[n] = moved;
            else if (code == 0) r[n] = (lv[n] == 0);
            else if (code == 1) r[n] = (lv[n] == 1);
            else if (code == 2) r[n] = moved && lv[n];
            else r[n] = moved && !lv[n];
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_st = '0; m_st_ne = '0;
        end else begin
            logic [N-1:0] clr;
            logic [N-1:0] d1, d0;
            clr = clr_v ? clr_b : '0;
            d1 = detect(m_s2, m_prev, anye);
            d0 = detect(m_s2, m_prev, '0);
            m_st    = (m_st & ~clr) | d1;
            m_st_ne = (m_st_ne & ~clr) | d0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
        end
    end

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // model comparison on every cycle
    always @(negedge clk) begin
        if (!done) begin
            check({phase, " model status"}, st, m_st);
            check({phase, " model status R12"}, st_ne, m_st_ne);
            check({phase, " model irq R10"}, {31'b0, irq}, {31'b0, |(m_st & mask)});
            check({phase, " model irq R10"}, {31'b0, irq_ne}, {31'b0, |(m_st_ne & mask)});
        end
    end

    task automatic step(int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    task automatic clear(logic [N-1:0] b);
        clr_v = 1'b1; clr_b = b;
        step(1);
        clr_v = 1'b0; clr_b = '0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        pins = 32'hFFFF_FFFF;
        step(3);
        check("R1 status in reset", st, '0);
        check("R1 irq in reset", {31'b0, irq}, '0);
        rst_n = 1'b1;
        pins = '0;
        step(1);
        check("R1 status after reset", st, '0);

        phase = "R2";
        cfg = {N{2'b01}}; anye = '1;
        pins = 32'h0F0F_0F0F; step(4);
        pins = 32'hF0F0_F0F0; step(4);
        check("R2 output lines silent", st, '0);
        pins = '0; anye = '0; step(4);

        phase = "R3";
        cfg = '0; dir = '1;
        step(1);
        check("R3 low level sets all", st, '1);

        phase = "R9";
        clear('1);
        check("R9 detection wins over clear", st, '1);

        phase = "R4";
        cfg = {N{2'b01}};
        clear('1);
        check("R4 high level idle", st, '0);
        pins = 32'h0000_00F0; step(3);
        check("R4 high level sets", st, 32'h0000_00F0);

        phase = "R8";
        pins = '0; step(4);
        check("R8 sticky after level gone", st, 32'h0000_00F0);
        clear(32'h0000_0010);
        check("R8 w1c single bit", st, 32'h0000_00E0);
        clear('0);
        check("R8 zero clear no effect", st, 32'h0000_00E0);

        phase = "R5";
        cfg = {N{2'b10}};
        clear('1);
        check("R5 rise idle", st, '0);
        pins = 32'h0000_0003; step(2);
        check("R11 not yet after two edges", st, '0);
        step(1);
        check("R11 R5 rising sets on third edge", st, 32'h0000_0003);
        clear('1);
        pins = '0; step(4);
        check("R5 falling ignored", st, '0);

        phase = "R6";
        cfg = {N{2'b11}};
        pins = 32'h0000_00FF; step(4);
        check("R6 rising ignored", st, '0);
        pins = '0; step(3);
        check("R6 falling sets", st, 32'h0000_00FF);
        clear('1);
        check("R6 clear", st, '0);

        phase = "R7";
        cfg = '0; anye = '1;
        clear('1);
        check("R7 steady level with override", st, '0);
        check("R12 override ignored, low level sets", st_ne, '1);
        pins = 32'h0000_0020; step(3);
        check("R7 change sets", st, 32'h0000_0020);
        pins = '0; step(4);
        check("R7 both edges, sticky", st, 32'h0000_0020);

        phase = "R10";
        mask = '0; step(1);
        check("R10 masked irq low", {31'b0, irq}, '0);
        mask = 32'h0000_0020; #1;
        check("R10 irq follows mask same cycle", {31'b0, irq}, 32'd1);
        mask = 32'h0000_0010; #1;
        check("R10 other mask irq low", {31'b0, irq}, '0);
        anye = '0; clear('1);

        phase = "mix";
        for (int i = 0; i < 3000; i++) begin
            pins = $urandom;
            if (i % 7 == 0) cfg = {$urandom, $urandom};
            if (i % 11 == 0) dir = $urandom;
            if (i % 13 == 0) anye = $urandom;
            mask = $urandom;
            clr_v = ($urandom % 3 == 0);
            clr_b = $urandom;
            step(1);
        end
        clr_v = 1'b0;
        step(2);
        finish_run();
    end
endmodule